// File: doc/BRIEF.md
# Universal Shift Register with Mode Select

This block is a clocked register of parameterised width, four bits by default. A two-bit mode input chooses what the register does at each rising clock edge. It can keep its value, shift one place toward the least significant end, shift one place toward the most significant end, or load a whole word in parallel. Each shift direction has its own serial input. Each bit's next value comes from a four-way selector, and all the selectors share the mode lines.

A synchronous clear input empties the register. Every bit of the register is driven on a parallel output at all times. Two serial outputs show the bit that leaves the register in each shift direction.

The register can be used to convert serial data to parallel form, to convert parallel data to serial form, or as a general staging register in a datapath.

Top module: `uni_shift_reg`

## Requirements
- R1: With mode 2'b00 and clear low, the register keeps its value across the clock edge.
- R2: With mode 2'b01, the register shifts right. `ser_in_r` enters the most significant bit, and every other bit takes the value its higher neighbour held before the edge.
- R3: With mode 2'b10, the register shifts left. `ser_in_l` enters the least significant bit, and every other bit takes the value its lower neighbour held before the edge.
- R4: With mode 2'b11, all bits of `par_in` are captured into the register at the same edge.
- R5: With `clr` high at a rising edge, every register bit becomes 0 after that edge.
- R6: Clear takes priority over every mode, so the serial inputs and `par_in` have no effect while `clr` is high.
- R7: `par_out` always shows every bit of the register.
- R8: `ser_out_r` equals the register's bit 0, and `ser_out_l` equals its most significant bit.
- R9: `WIDTH` is a parameter with a default of 4 and a minimum of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register updates on the rising edge |
| clr | input | 1 | Synchronous clear, active high, overrides the mode |
| mode | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 parallel load |
| ser_in_r | input | 1 | Serial data entering the MSB on a right shift |
| ser_in_l | input | 1 | Serial data entering the LSB on a left shift |
| par_in | input | WIDTH | Word captured in parallel-load mode |
| par_out | output | WIDTH | Present register contents |
| ser_out_r | output | 1 | Bit leaving on a right shift (the LSB) |
| ser_out_l | output | 1 | Bit leaving on a left shift (the MSB) |

## Verification
After the first clear, the assertions check on every clock that the output word follows each mode against its own value one cycle earlier. They check that a hold changes nothing, that each shift moves the word by one place with the correct serial bit, that a load captures `par_in`, and that a clear gives zero. The bench's sweep is the only place that shows the serial outputs at both ends of the word, with every start value and every combination of serial inputs. It is also the only place that shows the clear overriding each mode with nonzero data on the inputs, and that the default width holds.

// File: rtl/ushr_pkg.sv
package ushr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_SHR   = 2'b01,
        MODE_SHL   = 2'b10,
        MODE_LOAD  = 2'b11
    } ushr_mode_e;

endpackage

// File: rtl/ushr_bit_sel.sv
module ushr_bit_sel
    import ushr_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       cur_v,
    input  logic       from_hi,
    input  logic       from_lo,
    input  logic       par_v,
    output logic       nxt_v
);

    always_comb begin
        case (ushr_mode_e'(mode))
            MODE_HOLD: nxt_v = cur_v;
            MODE_SHR:  nxt_v = from_hi;
            MODE_SHL:  nxt_v = from_lo;
            default:   nxt_v = par_v;
        endcase
    end

endmodule

// File: rtl/uni_shift_reg.sv
module uni_shift_reg
    import ushr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [1:0]       mode,
    input  logic             ser_in_r,
    input  logic             ser_in_l,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] par_out,
    output logic             ser_out_r,
    output logic             ser_out_l
);

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } ushr_state_t;

    ushr_state_t      state_d;
    ushr_state_t      state_q;
    logic [WIDTH-1:0] sel_out;

    // R9: minimum width check
    initial begin
        a_r9_min_width: assert (WIDTH >= 2)
            else $error("uni_shift_reg: WIDTH must be at least 2");
    end

    // Per-bit four-way selectors; the end bits take the serial inputs
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic hi_src;
        logic lo_src;
        if (i == MSB) begin : g_top
            assign hi_src = ser_in_r;
        end else begin : g_mid_hi
            assign hi_src = state_q.word[i+1];
        end
        if (i == 0) begin : g_bot
            assign lo_src = ser_in_l;
        end else begin : g_mid_lo
            assign lo_src = state_q.word[i-1];
        end
        ushr_bit_sel u_sel (
            .mode    (mode),
            .cur_v   (state_q.word[i]),
            .from_hi (hi_src),
            .from_lo (lo_src),
            .par_v   (par_in[i]),
            .nxt_v   (sel_out[i])
        );
    end

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d.word = '0;
        end else begin
            state_d.word = sel_out;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign par_out   = state_q.word;
    assign ser_out_r = state_q.word[0];
    assign ser_out_l = state_q.word[MSB];

    // Checks are armed once a clear has defined the register contents
    logic armed_q;
    always_ff @(posedge clk) begin
        armed_q <= armed_q | clr;
    end

    a_r1_hold_keeps: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        (!clr && mode == 2'b00) |=> par_out == $past(par_out));

    a_r2_shift_right: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        (!clr && mode == 2'b01) |=>
            (par_out[MSB] == $past(ser_in_r)) && (par_out[MSB-1:0] == $past(par_out[MSB:1])));

    a_r3_shift_left: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        (!clr && mode == 2'b10) |=>
            (par_out[0] == $past(ser_in_l)) && (par_out[MSB:1] == $past(par_out[MSB-1:0])));

    a_r4_load: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        (!clr && mode == 2'b11) |=> par_out == $past(par_in));

    a_r5_r6_clear_wins: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        clr |=> par_out == '0);

endmodule

// File: tb/uni_shift_reg_tb.sv
`timescale 1ns/1ps
module uni_shift_reg_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr;
    logic [1:0]   mode;
    logic         ser_in_r;
    logic         ser_in_l;
    logic [W-1:0] par_in;
    logic [W-1:0] par_out;
    logic         ser_out_r;
    logic         ser_out_l;

    int n_cmp  = 0;
    int n_miss = 0;
    bit done   = 1'b0;
    logic [W-1:0] model;

    always #5 clk = ~clk;

    uni_shift_reg u_dut (
        .clk       (clk),
        .clr       (clr),
        .mode      (mode),
        .ser_in_r  (ser_in_r),
        .ser_in_l  (ser_in_l),
        .par_in    (par_in),
        .par_out   (par_out),
        .ser_out_r (ser_out_r),
        .ser_out_l (ser_out_l)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, compare at the next falling edge
    task automatic step(input logic c, input logic [1:0] m, input logic sr,
                        input logic sl, input logic [W-1:0] p, input string req);
        clr = c; mode = m; ser_in_r = sr; ser_in_l = sl; par_in = p;
        if (c) model = '0;
        else case (m)
            2'b00: model = model;
            2'b01: model = {sr, model[W-1:1]};
            2'b10: model = {model[W-2:0], sl};
            default: model = p;
        endcase
        @(posedge clk);
        @(negedge clk);
        check({req, "/R7 word"}, par_out, model);
        check("R8 ser_out_r", {{(W-1){1'b0}}, ser_out_r}, {{(W-1){1'b0}}, model[0]});
        check("R8 ser_out_l", {{(W-1){1'b0}}, ser_out_l}, {{(W-1){1'b0}}, model[W-1]});
    endtask

    initial begin
        clr = 1'b0; mode = 2'b00; ser_in_r = 1'b0; ser_in_l = 1'b0; par_in = '0;
        model = '0;
        @(negedge clk);
        // R5: clear from the unknown power-up state
        step(1'b1, 2'b00, 1'b0, 1'b0, '0, "R5");
        // R9: default width
        check("R9 width", W'($bits(par_out)), W'(4));
        for (int s = 0; s < (1 << W); s++) begin
            for (int m = 0; m < 4; m++) begin
                for (int b = 0; b < 4; b++) begin
                    step(1'b0, 2'b11, 1'b0, 1'b0, W'(s), "R4");
                    case (m)
                        0: step(1'b0, 2'b00, b[0], b[1], ~W'(s), "R1");
                        1: step(1'b0, 2'b01, b[0], b[1], ~W'(s), "R2");
                        2: step(1'b0, 2'b10, b[0], b[1], ~W'(s), "R3");
                        default: step(1'b0, 2'b11, b[0], b[1], W'(s ^ b), "R4");
                    endcase
                end
                // R6: clear overrides every mode while data inputs are active
                step(1'b0, 2'b11, 1'b0, 1'b0, W'(s) | W'(1), "R4");
                step(1'b1, 2'(m), 1'b1, 1'b1, '1, "R6");
            end
        end
        // R2/R3: a longer run of shifts
        step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1001, "R4");
        for (int k = 0; k < 6; k++) step(1'b0, 2'b01, k[0], 1'b0, '0, "R2");
        for (int k = 0; k < 6; k++) step(1'b0, 2'b10, 1'b0, ~k[0], '0, "R3");
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_cmp++;
            n_miss++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
            $finish;
        end
    end

endmodule